// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Integer Core

This block is a small integer processor that finishes one instruction on every clock edge. Each cycle it presents the program counter on an instruction fetch port. It decodes the returned 32-bit word, reads up to two operands from a 32-entry register file and computes a result. It then writes the result back, or issues a store on the data port, and chooses the next program counter. Both memory ports are combinational from the core's point of view: the word addressed in a cycle must be on the read-data input within that same cycle.

The core covers a compact load/store subset. It has register and immediate arithmetic, bitwise logic, shifts, signed compare, word and byte memory access, equality branches, and absolute and register-indirect jumps with a link form for calls. Anything outside the decoded set is executed as a no-op. It is meant as a control processor inside a larger design, paired with small local instruction and data memories.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a clock edge the program counter is loaded with 0, so the first fetch after reset is from address 0, and while `rst` is high `dmem_be` stays all-zero.
- R2: Any instruction that is not a branch or jump advances the fetch address by 4, and the fetch address always has its two low bits at zero.
- R3: With opcode 0 (bits 31:26), the field funct (bits 5:0) selects rd = rs op rt. The source fields are rs at bits 25:21 and rt at 20:16, and rd sits at bits 15:11. The codes are add 32, sub 34, and 36, or 37, nor 39 and slt 42. Add and sub wrap modulo 2^32, nor is NOT(rs OR rt), and slt writes 1 if rs < rt as signed values, else 0.
- R4: With opcode 0, funct 0 shifts rt left and funct 2 shifts rt right, both zero-filling. The shift amount comes from bits 10:6 and the result goes to rd.
- R5: The immediate forms write to rt using the 16-bit immediate in bits 15:0. Opcode 8 adds the sign-extended immediate to rs. Opcode 10 writes 1 if rs is less than the sign-extended immediate as signed values, else 0. Opcode 13 ORs rs with the zero-extended immediate. Opcode 15 writes immediate × 65536.
- R6: Register 0 reads as zero at all times; writes aimed at it are dropped.
- R7: Opcode 35 loads a word into rt and opcode 43 stores rt as a word. The byte address is rs plus the sign-extended 16-bit offset, and negative offsets work. A word store drives all four `dmem_be` bits.
- R8: Opcode 32 loads one byte, sign-extended, and opcode 40 stores the low byte of rt. Byte lanes are big-endian: address offset 0 is bits 31:24 and offset 3 is bits 7:0. A byte store drives only that lane's enable, with `dmem_be[3]` for offset 0, and repeats the byte on all lanes of `dmem_wdata`.
- R9: Opcode 4 branches when rs equals rt and opcode 5 when they differ. The target is PC + 4 + 4 × sign-extended immediate; otherwise execution continues at PC + 4.
- R10: Opcode 2 jumps to {(PC+4)[31:28], bits 25:0, 2'b00}. Opcode 3 does the same and also writes PC + 4 into register 31.
- R11: Opcode 0 with funct 8 jumps to the value of rs with its two low bits cleared.
- R12: Any other opcode, and any other funct under opcode 0, writes no register, issues no store and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction being executed |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, valid in the same cycle |
| dmem_addr | output | 32 | Byte address of the load or store |
| dmem_rdata | input | 32 | Aligned word containing `dmem_addr`, valid in the same cycle |
| dmem_wdata | output | 32 | Store data, byte repeated on all lanes for byte stores |
| dmem_be | output | 4 | Per-lane write enables; bit 3 is bits 31:24; all-zero means no store |

## Verification
The assertions watch the fetch and store ports on every cycle. They check that the PC is 0 after reset, stays word aligned and steps by 4 on non-control words. They check the absolute jump target, and that word stores enable four lanes and byte stores exactly one. They also check that no store comes from any opcode other than the two store opcodes. Arithmetic results, register 0, the big-endian lane choice, branch direction, link values and the no-op treatment of undefined words show up only in data memory contents and final fetch addresses. The bench's programs expose these, sweeping operand and immediate corner values and every shift amount.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

  localparam int INSTR_W = 32;

  localparam logic [5:0] OP_SPECIAL = 6'd0;
  localparam logic [5:0] OP_J       = 6'd2;
  localparam logic [5:0] OP_JAL     = 6'd3;
  localparam logic [5:0] OP_BEQ     = 6'd4;
  localparam logic [5:0] OP_BNE     = 6'd5;
  localparam logic [5:0] OP_ADDI    = 6'd8;
  localparam logic [5:0] OP_SLTI    = 6'd10;
  localparam logic [5:0] OP_ORI     = 6'd13;
  localparam logic [5:0] OP_LUI     = 6'd15;
  localparam logic [5:0] OP_LB      = 6'd32;
  localparam logic [5:0] OP_LW      = 6'd35;
  localparam logic [5:0] OP_SB      = 6'd40;
  localparam logic [5:0] OP_SW      = 6'd43;

  localparam logic [5:0] FN_SLL = 6'd0;
  localparam logic [5:0] FN_SRL = 6'd2;
  localparam logic [5:0] FN_JR  = 6'd8;
  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_NOR = 6'd39;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR,
    ALU_SLT, ALU_SLL, ALU_SRL, ALU_HIGH
  } alu_op_e;

  typedef enum logic [1:0] {DST_NONE, DST_RD, DST_RT, DST_LINK} dst_sel_e;
  typedef enum logic [1:0] {WB_ALU, WB_LOAD, WB_LINK} wb_sel_e;
  typedef enum logic [2:0] {PCN_SEQ, PCN_EQ, PCN_NE, PCN_ABS, PCN_REG} pc_sel_e;

  typedef struct packed {
    dst_sel_e dst;
    wb_sel_e  wb;
    logic     b_imm;
    logic     imm_zext;
    alu_op_e  alu;
    logic     ld_byte;
    logic     st_word;
    logic     st_byte;
    pc_sel_e  pcn;
  } ctrl_t;

endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
  import sc_core_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '{dst: DST_NONE, wb: WB_ALU, b_imm: 1'b0, imm_zext: 1'b0,
             alu: ALU_ADD, ld_byte: 1'b0, st_word: 1'b0, st_byte: 1'b0,
             pcn: PCN_SEQ};
    case (opcode)
      OP_SPECIAL: begin
        case (funct)
          FN_ADD: begin ctrl.dst = DST_RD; ctrl.alu = ALU_ADD; end
          FN_SUB: begin ctrl.dst = DST_RD; ctrl.alu = ALU_SUB; end
          FN_AND: begin ctrl.dst = DST_RD; ctrl.alu = ALU_AND; end
          FN_OR:  begin ctrl.dst = DST_RD; ctrl.alu = ALU_OR;  end
          FN_NOR: begin ctrl.dst = DST_RD; ctrl.alu = ALU_NOR; end
          FN_SLT: begin ctrl.dst = DST_RD; ctrl.alu = ALU_SLT; end
          FN_SLL: begin ctrl.dst = DST_RD; ctrl.alu = ALU_SLL; end
          FN_SRL: begin ctrl.dst = DST_RD; ctrl.alu = ALU_SRL; end
          FN_JR:  ctrl.pcn = PCN_REG;
          default: ;
        endcase
      end
      OP_ADDI: begin ctrl.dst = DST_RT; ctrl.b_imm = 1'b1; ctrl.alu = ALU_ADD; end
      OP_SLTI: begin ctrl.dst = DST_RT; ctrl.b_imm = 1'b1; ctrl.alu = ALU_SLT; end
      OP_ORI: begin
        ctrl.dst = DST_RT; ctrl.b_imm = 1'b1; ctrl.imm_zext = 1'b1; ctrl.alu = ALU_OR;
      end
      OP_LUI:  begin ctrl.dst = DST_RT; ctrl.b_imm = 1'b1; ctrl.alu = ALU_HIGH; end
      OP_LW:   begin ctrl.dst = DST_RT; ctrl.wb = WB_LOAD; ctrl.b_imm = 1'b1; end
      OP_LB: begin
        ctrl.dst = DST_RT; ctrl.wb = WB_LOAD; ctrl.b_imm = 1'b1; ctrl.ld_byte = 1'b1;
      end
      OP_SW:   begin ctrl.b_imm = 1'b1; ctrl.st_word = 1'b1; end
      OP_SB:   begin ctrl.b_imm = 1'b1; ctrl.st_byte = 1'b1; end
      OP_BEQ:  ctrl.pcn = PCN_EQ;
      OP_BNE:  ctrl.pcn = PCN_NE;
      OP_J:    ctrl.pcn = PCN_ABS;
      OP_JAL:  begin ctrl.pcn = PCN_ABS; ctrl.dst = DST_LINK; ctrl.wb = WB_LINK; end
      default: ;
    endcase
  end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 32,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr_a,
  input  logic [AW-1:0]     raddr_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);

  logic [DATA_W-1:0] store_q [NUM_REGS];

  // Entry 0 is never written; reads of it are forced to zero below.
  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) store_q[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : store_q[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : store_q[raddr_b];

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [SH_W-1:0]   shamt,
  output logic [DATA_W-1:0] y
);

  localparam int HALF = DATA_W / 2;

  always_comb begin
    y = '0;
    case (op)
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_AND:  y = a & b;
      ALU_OR:   y = a | b;
      ALU_NOR:  y = ~(a | b);
      ALU_SLT:  y[0] = ($signed(a) < $signed(b));
      ALU_SLL:  y = b << shamt;
      ALU_SRL:  y = b >> shamt;
      ALU_HIGH: y = b << HALF;
      default:  y = '0;
    endcase
  end

endmodule

// File: rtl/sc_lane_ctl.sv
module sc_lane_ctl #(
  parameter int DATA_W   = 32,
  localparam int LANES   = DATA_W / 8,
  localparam int LANE_AW = $clog2(LANES)
) (
  input  logic [LANE_AW-1:0] addr_lo,
  input  logic               st_word,
  input  logic               st_byte,
  input  logic               ld_byte,
  input  logic [DATA_W-1:0]  store_data,
  input  logic [DATA_W-1:0]  load_word,
  output logic [LANES-1:0]   be,
  output logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  ld_data
);

  logic [7:0]         lane_byte [LANES];
  logic [LANE_AW-1:0] lane_idx;
  logic [7:0]         picked;

  // Big-endian: offset 0 lives in the most significant lane.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_byte[i] = load_word[i*8 +: 8];
    assign be[i] = st_word | (st_byte && (addr_lo == LANE_AW'(LANES - 1 - i)));
  end

  assign lane_idx = LANE_AW'(LANES - 1) - addr_lo;
  assign picked   = lane_byte[lane_idx];
  assign wdata    = st_byte ? {LANES{store_data[7:0]}} : store_data;
  assign ld_data  = ld_byte ? {{(DATA_W-8){picked[7]}}, picked} : load_word;

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter int DATA_W            = 32,
  parameter int NUM_REGS          = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic                clk,
  input  logic                rst,
  output logic [DATA_W-1:0]   imem_addr,
  input  logic [INSTR_W-1:0]  imem_rdata,
  output logic [DATA_W-1:0]   dmem_addr,
  input  logic [DATA_W-1:0]   dmem_rdata,
  output logic [DATA_W-1:0]   dmem_wdata,
  output logic [DATA_W/8-1:0] dmem_be
);

  localparam int LANES    = DATA_W / 8;
  localparam int LANE_AW  = $clog2(LANES);
  localparam int REG_AW   = $clog2(NUM_REGS);
  localparam int SH_W     = $clog2(DATA_W);
  localparam int LINK_REG = NUM_REGS - 1;
  localparam int IMM_W    = 16;
  localparam int TGT_W    = 26;

  // Instruction fields
  logic [5:0]       f_op, f_funct;
  logic [4:0]       f_rs, f_rt, f_rd, f_sh;
  logic [IMM_W-1:0] f_imm;
  logic [TGT_W-1:0] f_tgt;

  assign f_op    = imem_rdata[31:26];
  assign f_rs    = imem_rdata[25:21];
  assign f_rt    = imem_rdata[20:16];
  assign f_rd    = imem_rdata[15:11];
  assign f_sh    = imem_rdata[10:6];
  assign f_funct = imem_rdata[5:0];
  assign f_imm   = imem_rdata[15:0];
  assign f_tgt   = imem_rdata[25:0];

  ctrl_t ctrl;

  sc_decoder u_dec (
    .opcode (f_op),
    .funct  (f_funct),
    .ctrl   (ctrl)
  );

  // Register file
  logic              rf_we;
  logic [REG_AW-1:0] rf_waddr;
  logic [DATA_W-1:0] rf_wdata, op_a, op_b;

  always_comb begin
    case (ctrl.dst)
      DST_RD:   rf_waddr = REG_AW'(f_rd);
      DST_RT:   rf_waddr = REG_AW'(f_rt);
      DST_LINK: rf_waddr = REG_AW'(LINK_REG);
      default:  rf_waddr = '0;
    endcase
  end

  assign rf_we = (ctrl.dst != DST_NONE) && !rst;

  sc_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rf (
    .clk     (clk),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata),
    .raddr_a (REG_AW'(f_rs)),
    .raddr_b (REG_AW'(f_rt)),
    .rdata_a (op_a),
    .rdata_b (op_b)
  );

  // Operand B and ALU
  logic [DATA_W-1:0] imm_sext, imm_ext, alu_b, alu_y;

  assign imm_sext = {{(DATA_W-IMM_W){f_imm[IMM_W-1]}}, f_imm};
  assign imm_ext  = ctrl.imm_zext ? {{(DATA_W-IMM_W){1'b0}}, f_imm} : imm_sext;
  assign alu_b    = ctrl.b_imm ? imm_ext : op_b;

  sc_alu #(.DATA_W(DATA_W)) u_alu (
    .op    (ctrl.alu),
    .a     (op_a),
    .b     (alu_b),
    .shamt (SH_W'(f_sh)),
    .y     (alu_y)
  );

  // Data memory lanes
  logic [LANES-1:0]  lane_be;
  logic [DATA_W-1:0] ld_data;

  sc_lane_ctl #(.DATA_W(DATA_W)) u_lane (
    .addr_lo    (alu_y[LANE_AW-1:0]),
    .st_word    (ctrl.st_word),
    .st_byte    (ctrl.st_byte),
    .ld_byte    (ctrl.ld_byte),
    .store_data (op_b),
    .load_word  (dmem_rdata),
    .be         (lane_be),
    .wdata      (dmem_wdata),
    .ld_data    (ld_data)
  );

  assign dmem_addr = alu_y;
  assign dmem_be   = rst ? '0 : lane_be;

  // Program counter
  logic [DATA_W-1:0] pc_q, pc_plus4, pc_br, pc_next;

  assign pc_plus4 = pc_q + DATA_W'(4);
  assign pc_br    = pc_plus4 + (imm_sext << 2);

  always_comb begin
    case (ctrl.pcn)
      PCN_EQ:  pc_next = (op_a == op_b) ? pc_br : pc_plus4;
      PCN_NE:  pc_next = (op_a != op_b) ? pc_br : pc_plus4;
      PCN_ABS: pc_next = {pc_plus4[DATA_W-1:TGT_W+2], f_tgt, 2'b00};
      PCN_REG: pc_next = {op_a[DATA_W-1:2], 2'b00};
      default: pc_next = pc_plus4;
    endcase
  end

  always_comb begin
    case (ctrl.wb)
      WB_LOAD: rf_wdata = ld_data;
      WB_LINK: rf_wdata = pc_plus4;
      default: rf_wdata = alu_y;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= DATA_W'(RESET_PC);
    else     pc_q <= pc_next;
  end

  assign imem_addr = pc_q;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk #(
  parameter int DATA_W            = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input logic                clk,
  input logic                rst,
  input logic [DATA_W-1:0]   imem_addr,
  input logic [31:0]         imem_rdata,
  input logic [DATA_W/8-1:0] dmem_be
);

  logic [5:0]        op, fn;
  logic              is_ctl;
  logic [DATA_W-1:0] seq_pc;
  logic              rst_d;

  assign op     = imem_rdata[31:26];
  assign fn     = imem_rdata[5:0];
  assign is_ctl = (op == 6'd2) || (op == 6'd3) || (op == 6'd4) || (op == 6'd5) ||
                  ((op == 6'd0) && (fn == 6'd8));
  assign seq_pc = imem_addr + DATA_W'(4);

  always_ff @(posedge clk) rst_d <= rst;

  always_ff @(posedge clk) begin
    // R1
    if (rst_d) begin
      reset_pc_chk: assert (imem_addr == DATA_W'(RESET_PC))
        else $error("pc not at reset value after reset");
    end
    // R1
    if (rst) begin
      reset_nostore_chk: assert (dmem_be == '0)
        else $error("store enabled during reset");
    end
  end

  // R2
  pc_align_chk: assert property (@(posedge clk) disable iff (rst)
    imem_addr[1:0] == 2'b00);

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    !is_ctl |=> imem_addr == $past(seq_pc));

  // R7
  sw_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 6'd43) |-> dmem_be == '1);

  // R8
  sb_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 6'd40) |-> $countones(dmem_be) == 1);

  // R12
  store_src_chk: assert property (@(posedge clk) disable iff (rst)
    (dmem_be != '0) |-> ((op == 6'd43) || (op == 6'd40)));

  // R10
  jump_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    ((op == 6'd2) || (op == 6'd3)) |=>
      (imem_addr[DATA_W-1:28] == $past(seq_pc[DATA_W-1:28])) &&
      (imem_addr[27:0] == {$past(imem_rdata[25:0]), 2'b00}));

endmodule

bind sc_core sc_core_chk #(.DATA_W(DATA_W), .RESET_PC(RESET_PC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .imem_addr  (imem_addr),
  .imem_rdata (imem_rdata),
  .dmem_be    (dmem_be)
);

// File: tb/sc_core_bench.sv
module sc_core_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 256;
  localparam logic [31:0] HALT = {6'd4, 5'd0, 5'd0, 16'hFFFF};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_rdata, dmem_wdata;
  logic [3:0]  dmem_be;
  logic [31:0] imem [MEM_WORDS];
  logic [31:0] dmem [MEM_WORDS];
  int checks = 0;
  int errors = 0;
  int nw = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_core u_sc_core (
    .clk (clk), .rst (rst),
    .imem_addr (imem_addr), .imem_rdata (imem_rdata),
    .dmem_addr (dmem_addr), .dmem_rdata (dmem_rdata),
    .dmem_wdata (dmem_wdata), .dmem_be (dmem_be)
  );

  assign imem_rdata = imem[imem_addr[9:2]];
  assign dmem_rdata = dmem[dmem_addr[9:2]];

  always @(posedge clk)
    for (int k = 0; k < 4; k++)
      if (dmem_be[k]) dmem[dmem_addr[9:2]][k*8 +: 8] <= dmem_wdata[k*8 +: 8];

  function automatic logic [31:0] enc_r(int fn, int rs, int rt, int rd, int sh);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction
  function automatic logic [31:0] enc_i(int op, int rs, int rt, logic [15:0] imm);
    return {6'(op), 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] enc_j(int op, logic [25:0] t);
    return {6'(op), t};
  endfunction

  function automatic logic [31:0] ref_r(int fn, logic [31:0] a, logic [31:0] b);
    case (fn)
      32: return a + b;
      34: return a - b;
      36: return a & b;
      37: return a | b;
      39: return ~(a | b);
      default: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    endcase
  endfunction
  function automatic logic [31:0] ref_i(int op, logic [31:0] a, logic [15:0] imm);
    logic [31:0] s;
    s = {{16{imm[15]}}, imm};
    case (op)
      8:  return a + s;
      10: return ($signed(a) < $signed(s)) ? 32'd1 : 32'd0;
      13: return a | {16'd0, imm};
      default: return {imm, 16'd0};
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic new_prog();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    for (int k = 0; k < MEM_WORDS; k++) begin
      imem[k] = HALT;
      dmem[k] = 32'h0;
    end
    nw = 0;
  endtask
  task automatic emit(logic [31:0] w);
    imem[nw] = w;
    nw++;
  endtask
  task automatic set_reg(int r, logic [31:0] v);
    emit(enc_i(15, 0, r, v[31:16]));
    emit(enc_i(13, r, r, v[15:0]));
  endtask
  task automatic run(int cycles);
    @(negedge clk);
    rst = 1'b0;
    repeat (cycles) @(negedge clk);
  endtask

  logic [31:0] vals [6] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                            32'h8000_0000, 32'h1234_ABCD};
  logic [15:0] imms [6] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};
  int fns [6]  = '{32, 34, 36, 37, 39, 42};
  int iops [4] = '{8, 10, 13, 15};

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset holds PC at 0 and blocks a store at address 0
    new_prog();
    emit(enc_i(43, 0, 0, 16'h0));
    @(posedge clk);
    @(negedge clk);
    check("R1", "fetch address in reset", imem_addr, 32'h0);
    check("R1", "store enable in reset", {28'h0, dmem_be}, 32'h0);

    // R3 / R2: register-register sweep
    foreach (fns[f]) foreach (vals[i]) foreach (vals[j]) begin
      new_prog();
      set_reg(1, vals[i]);
      set_reg(2, vals[j]);
      emit(enc_r(fns[f], 1, 2, 3, 0));
      emit(enc_i(43, 0, 3, 16'h0));
      run(8);
      check("R3", $sformatf("funct %0d", fns[f]), dmem[0], ref_r(fns[f], vals[i], vals[j]));
      check("R2", "sequential fetch reaches halt", imem_addr, 32'd24);
    end

    // R4: every shift amount, both directions
    for (int sh = 0; sh < 32; sh++) begin
      new_prog();
      set_reg(2, 32'h8000_0001 ^ (32'h0F0F_3C3C << (sh % 4)));
      emit(enc_r(0, 0, 2, 3, sh));
      emit(enc_r(2, 0, 2, 4, sh));
      emit(enc_i(43, 0, 3, 16'h0));
      emit(enc_i(43, 0, 4, 16'h4));
      run(9);
      check("R4", $sformatf("sll %0d", sh), dmem[0], (32'h8000_0001 ^ (32'h0F0F_3C3C << (sh % 4))) << sh);
      check("R4", $sformatf("srl %0d", sh), dmem[1], (32'h8000_0001 ^ (32'h0F0F_3C3C << (sh % 4))) >> sh);
    end

    // R5: immediate forms
    foreach (iops[o]) foreach (vals[i]) foreach (imms[m]) begin
      new_prog();
      set_reg(1, vals[i]);
      emit(enc_i(iops[o], 1, 3, imms[m]));
      emit(enc_i(43, 0, 3, 16'h0));
      run(6);
      check("R5", $sformatf("opcode %0d imm %h", iops[o], imms[m]), dmem[0],
            ref_i(iops[o], vals[i], imms[m]));
    end

    // R6: register 0 stays zero
    new_prog();
    dmem[0] = 32'hDEAD_BEEF;
    set_reg(1, 32'd123);
    emit(enc_i(8, 1, 0, 16'd5));
    emit(enc_r(32, 1, 1, 0, 0));
    emit(enc_r(32, 0, 1, 2, 0));
    emit(enc_i(43, 0, 0, 16'h0));
    emit(enc_i(43, 0, 2, 16'h4));
    run(10);
    check("R6", "store of r0", dmem[0], 32'h0);
    check("R6", "r0 used as source", dmem[1], 32'd123);

    // R7: word access with negative and positive offsets
    new_prog();
    dmem[15] = 32'h1357_9BDF;
    set_reg(5, 32'h40);
    set_reg(1, 32'hCAFE_F00D);
    emit(enc_i(43, 5, 1, 16'hFFF8));
    emit(enc_i(35, 5, 6, 16'hFFFC));
    emit(enc_i(43, 5, 6, 16'h0008));
    run(10);
    check("R7", "sw base-8", dmem[14], 32'hCAFE_F00D);
    check("R7", "lw base-4 copied to base+8", dmem[18], 32'h1357_9BDF);

    // R8: byte loads on every lane, byte store on every lane
    new_prog();
    dmem[20] = 32'h807F_01FE;
    for (int k = 0; k < 4; k++) begin
      emit(enc_i(32, 0, 2, 16'(32'h50 + k)));
      emit(enc_i(43, 0, 2, 16'(32'h60 + 4*k)));
    end
    run(11);
    check("R8", "lb offset 0", dmem[24], 32'hFFFF_FF80);
    check("R8", "lb offset 1", dmem[25], 32'h0000_007F);
    check("R8", "lb offset 2", dmem[26], 32'h0000_0001);
    check("R8", "lb offset 3", dmem[27], 32'hFFFF_FFFE);
    for (int k = 0; k < 4; k++) begin
      new_prog();
      dmem[28] = 32'h1122_3344;
      set_reg(3, 32'h0000_77A5);
      emit(enc_i(40, 0, 3, 16'(32'h70 + k)));
      run(6);
      check("R8", $sformatf("sb offset %0d", k), dmem[28],
            (32'h1122_3344 & ~(32'hFF00_0000 >> (8*k))) | (32'hA500_0000 >> (8*k)));
    end

    // R9: taken/not-taken branches, forward and backward
    new_prog();
    dmem[0] = 32'hAAAA;
    dmem[2] = 32'hBBBB;
    set_reg(1, 32'd5);
    set_reg(2, 32'd5);
    emit(enc_i(4, 1, 2, 16'd1));
    emit(enc_i(43, 0, 1, 16'd0));
    emit(enc_i(5, 1, 2, 16'd1));
    emit(enc_i(43, 0, 2, 16'd4));
    emit(enc_i(8, 0, 3, 16'd7));
    emit(enc_i(5, 1, 3, 16'd2));
    emit(enc_i(43, 0, 3, 16'd8));
    emit(enc_i(43, 0, 3, 16'd8));
    emit(enc_i(43, 0, 3, 16'd12));
    emit(enc_i(8, 0, 6, 16'd3));
    emit(enc_i(8, 0, 4, 16'd0));
    emit(enc_i(8, 4, 4, 16'd1));
    emit(enc_i(5, 4, 6, 16'hFFFE));
    emit(enc_i(43, 0, 4, 16'd16));
    run(30);
    check("R9", "taken beq skips store", dmem[0], 32'hAAAA);
    check("R9", "untaken bne falls through", dmem[1], 32'd5);
    check("R9", "taken bne skips two", dmem[2], 32'hBBBB);
    check("R9", "bne target store", dmem[3], 32'd7);
    check("R9", "backward loop count", dmem[4], 32'd3);

    // R10 / R11: call, return, jump, register jump to unaligned value
    new_prog();
    dmem[2] = 32'hCCCC;
    emit(enc_j(3, 26'd4));
    emit(enc_i(43, 0, 31, 16'd0));
    emit(enc_j(2, 26'd6));
    emit(enc_i(43, 0, 31, 16'd8));
    emit(enc_i(8, 0, 7, 16'h33));
    emit(enc_r(8, 31, 0, 0, 0));
    emit(enc_i(43, 0, 7, 16'd4));
    set_reg(8, 32'd42);
    emit(enc_r(8, 8, 0, 0, 0));
    emit(enc_i(43, 0, 8, 16'd12));
    run(16);
    check("R10", "jal link value", dmem[0], 32'd4);
    check("R10", "j skips word 3", dmem[2], 32'hCCCC);
    check("R11", "jr returns to caller", dmem[1], 32'h33);
    check("R11", "jr target store", dmem[3], 32'd42);
    check("R11", "low bits cleared, halt at 44", imem_addr, 32'd44);

    // R12: undefined encodings are no-ops
    new_prog();
    dmem[2] = 32'h5A5A;
    set_reg(1, 32'h55);
    emit(32'hFC22_0008);
    emit(enc_r(1, 1, 1, 1, 0));
    emit({6'd58, 5'd0, 5'd1, 16'h0008});
    emit(enc_i(43, 0, 1, 16'd0));
    run(9);
    check("R12", "register unchanged", dmem[0], 32'h55);
    check("R12", "memory untouched", dmem[2], 32'h5A5A);
    check("R12", "pc stepped past undefined words", imem_addr, 32'd24);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule